// File: doc/BRIEF.md
# Modulated Fractional Baud Rate Generator

This block produces the bit timing for an asynchronous serial channel. It counts ticks of a selected source clock and ends a bit period after a programmed number of them. The base count comes from a 16-bit prescaler value. An 8-entry modulation pattern then lets selected bit periods run one source tick longer than the base. Over eight periods the mean length can sit between two integers, and divisors far below the usual factor of 16 become usable.

Each period yields a one-cycle `bit_tick` when it ends. A `half_tick` marks the sampling centre, INT(N/2) source ticks into the period. The pattern is consumed least significant bit first, and the first bit belongs to the period that follows a restart. A restart comes from the frame-start strobe, which a receiver raises on a start-bit edge and a transmitter raises when a frame begins. A soft reset also restarts the block.

The source is one of three. It can be an external clock pin, synchronised and given selectable polarity. It can be an auxiliary tick strobe. It can be every cycle of the block's own clock. All logic runs on `clk`, and each source acts as a count enable.

Top module: `baud_mod_gen`

## Requirements
- R1: While reset is held, and after release until the first completed period or half period, `bit_tick` and `half_tick` are 0.
- R2: Let N be the clamped prescaler value and m the modulation bit for the current period. A period lasts N+m source ticks, and `bit_tick` pulses for one cycle in the cycle after the edge that consumed the last tick. Modulation bit k (bit 0 = LSB) applies to the k-th period after a restart, counting from 0. With N=6 and pattern 8'h6F the lengths are 7,7,7,7,6,7,7,6. With N=54 and pattern 8'hD5 they are 55,54,55,54,55,54,55,55.
- R3: After pattern bit 7, the next period uses bit 0 again, so the length sequence repeats every 8 periods.
- R4: `half_tick` pulses once per period, after INT(N/2) source ticks of that period, whatever the modulation bit.
- R5: A prescaler value of 0, 1 or 2 behaves as 3.
- R6: `frame_start` high at a clock edge clears the tick count and the pattern index. A source tick in that same cycle is not counted. Neither output pulses in the following cycle.
- R7: `soft_rst` restarts the block exactly as `frame_start` does.
- R8: `src_sel` encoding: 0 = external pin, 1 = `aux_tick` strobe (one tick per cycle it is high), 2 or 3 = every `clk` cycle. Without ticks from the selected source, no output pulses.
- R9: The external pin passes through a two-stage synchroniser. With `ext_inv`=0 each rising edge is one tick. With `ext_inv`=1 each falling edge is one tick.
- R10: `bit_tick` and `half_tick` are never high in the same cycle, and `bit_tick` is never high in two consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| soft_rst | input | 1 | Synchronous restart of count and pattern index |
| frame_start | input | 1 | Restart strobe at a frame start |
| src_sel | input | 2 | Source select: 0 external, 1 auxiliary, 2/3 main |
| ext_clk_in | input | 1 | External clock pin |
| ext_inv | input | 1 | Invert the external clock before edge detection |
| aux_tick | input | 1 | Auxiliary source strobe |
| prescale | input | 16 | Base divisor N (values below 3 act as 3) |
| mod_pattern | input | 8 | Per-period stretch pattern, LSB first |
| bit_tick | output | 1 | One-cycle pulse at each bit period end |
| half_tick | output | 1 | One-cycle pulse at the sampling centre |

## Verification
The two stated divisor and pattern pairs are run first. They fix both the LSB-first order and the absolute alignment of the first stretched period to the restart. Random divisors and patterns, fed through sparse auxiliary strobes, separate counting of source ticks from counting of clock cycles. Runs of sixteen periods expose a wrong wrap of the pattern index. Directed cases cover divisors 0 to 2, a soft restart in the middle of a period, and single edges of each polarity on the external pin. These show whether the clamp, the restart and the edge polarity each act as specified.

// File: rtl/baud_mod_pkg.sv
package baud_mod_pkg;

  typedef enum logic [1:0] {
    SRC_EXT      = 2'd0,
    SRC_AUX      = 2'd1,
    SRC_MAIN     = 2'd2,
    SRC_MAIN_ALT = 2'd3
  } src_sel_e;

  localparam int unsigned MIN_DIVISOR = 3;

endpackage

// File: rtl/baud_src_select.sv
module baud_src_select
  import baud_mod_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] src_sel,
  input  logic       ext_clk_in,
  input  logic       ext_inv,
  input  logic       aux_tick,
  output logic       src_tick
);

  logic [SYNC_STAGES-1:0] sync_q, sync_d;
  logic                   ext_prev_q, ext_prev_d;
  logic                   ext_level;
  logic                   ext_edge;

  // Synchroniser shift and polarity-adjusted edge detection
  always_comb begin
    sync_d     = {sync_q[SYNC_STAGES-2:0], ext_clk_in};
    ext_level  = sync_q[SYNC_STAGES-1] ^ ext_inv;
    ext_prev_d = ext_level;
    ext_edge   = ext_level & ~ext_prev_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q     <= '0;
      ext_prev_q <= 1'b0;
    end else begin
      sync_q     <= sync_d;
      ext_prev_q <= ext_prev_d;
    end
  end

  always_comb begin
    unique case (src_sel_e'(src_sel))
      SRC_EXT:      src_tick = ext_edge;
      SRC_AUX:      src_tick = aux_tick;
      SRC_MAIN,
      SRC_MAIN_ALT: src_tick = 1'b1;
      default:      src_tick = 1'b0;
    endcase
  end

endmodule

// File: rtl/baud_mod_seq.sv
module baud_mod_seq #(
  parameter int MOD_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             restart,
  input  logic             advance,
  input  logic [MOD_W-1:0] pattern,
  output logic             mod_bit
);

  localparam int IDX_W = (MOD_W > 1) ? $clog2(MOD_W) : 1;
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(MOD_W - 1);

  logic [IDX_W-1:0] idx_q, idx_d;

  always_comb begin
    idx_d = idx_q;
    if (restart) begin
      idx_d = '0;
    end else if (advance) begin
      idx_d = (idx_q == LAST_IDX) ? '0 : idx_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) idx_q <= '0;
    else        idx_q <= idx_d;
  end

  assign mod_bit = pattern[idx_q];

endmodule

// File: rtl/baud_period_cnt.sv
module baud_period_cnt #(
  parameter int PRE_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             restart,
  input  logic             src_tick,
  input  logic [PRE_W-1:0] base_div,
  input  logic             mod_bit,
  output logic             period_end,
  output logic             bit_tick,
  output logic             half_tick
);

  localparam int CNT_W = PRE_W + 1;

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [CNT_W-1:0] cnt_inc;
  logic [CNT_W-1:0] period_len;
  logic [CNT_W-1:0] half_len;
  logic             counting;
  logic             half_hit;
  logic             bit_q, bit_d;
  logic             half_q, half_d;

  always_comb begin
    counting   = src_tick & ~restart;
    cnt_inc    = cnt_q + 1'b1;
    period_len = {1'b0, base_div} + CNT_W'(mod_bit);
    half_len   = {1'b0, base_div >> 1};
    period_end = counting & (cnt_inc == period_len);
    half_hit   = counting & (cnt_inc == half_len);

    cnt_d = cnt_q;
    if (restart || period_end) cnt_d = '0;
    else if (counting)         cnt_d = cnt_inc;

    bit_d  = period_end;
    half_d = half_hit;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      bit_q  <= 1'b0;
      half_q <= 1'b0;
    end else begin
      cnt_q  <= cnt_d;
      bit_q  <= bit_d;
      half_q <= half_d;
    end
  end

  assign bit_tick  = bit_q;
  assign half_tick = half_q;

endmodule

// File: rtl/baud_mod_gen.sv
module baud_mod_gen
  import baud_mod_pkg::*;
#(
  parameter int PRE_W       = 16,
  parameter int MOD_W       = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             soft_rst,
  input  logic             frame_start,
  input  logic [1:0]       src_sel,
  input  logic             ext_clk_in,
  input  logic             ext_inv,
  input  logic             aux_tick,
  input  logic [PRE_W-1:0] prescale,
  input  logic [MOD_W-1:0] mod_pattern,
  output logic             bit_tick,
  output logic             half_tick
);

  localparam logic [PRE_W-1:0] DIV_FLOOR = PRE_W'(MIN_DIVISOR);

  logic             restart;
  logic             src_tick;
  logic [PRE_W-1:0] base_div;
  logic             mod_bit;
  logic             period_end;

  always_comb begin
    restart  = frame_start | soft_rst;
    base_div = (prescale < DIV_FLOOR) ? DIV_FLOOR : prescale;
  end

  baud_src_select #(.SYNC_STAGES(SYNC_STAGES)) u_src (
    .clk        (clk),
    .rst_n      (rst_n),
    .src_sel    (src_sel),
    .ext_clk_in (ext_clk_in),
    .ext_inv    (ext_inv),
    .aux_tick   (aux_tick),
    .src_tick   (src_tick)
  );

  baud_mod_seq #(.MOD_W(MOD_W)) u_seq (
    .clk     (clk),
    .rst_n   (rst_n),
    .restart (restart),
    .advance (period_end),
    .pattern (mod_pattern),
    .mod_bit (mod_bit)
  );

  baud_period_cnt #(.PRE_W(PRE_W)) u_cnt (
    .clk        (clk),
    .rst_n      (rst_n),
    .restart    (restart),
    .src_tick   (src_tick),
    .base_div   (base_div),
    .mod_bit    (mod_bit),
    .period_end (period_end),
    .bit_tick   (bit_tick),
    .half_tick  (half_tick)
  );

endmodule

// File: rtl/baud_mod_gen_chk.sv
module baud_mod_gen_chk (
  input logic clk,
  input logic rst_n,
  input logic restart,
  input logic src_tick,
  input logic bit_tick,
  input logic half_tick
);

  logic seen_half_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         seen_half_q <= 1'b0;
    else if (restart)   seen_half_q <= 1'b0;
    else if (bit_tick)  seen_half_q <= 1'b0;
    else if (half_tick) seen_half_q <= 1'b1;
  end

  p_ticks_exclusive_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !(bit_tick && half_tick));

  p_bit_single_r10: assert property (@(posedge clk) disable iff (!rst_n)
    bit_tick |=> !bit_tick);

  // Covers R6 and R7: both feed the restart path
  p_restart_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
    restart |=> (!bit_tick && !half_tick));

  p_needs_source_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !src_tick |=> (!bit_tick && !half_tick));

  p_half_precedes_bit_r4: assert property (@(posedge clk) disable iff (!rst_n)
    bit_tick |-> seen_half_q);

endmodule

bind baud_mod_gen baud_mod_gen_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .restart   (restart),
  .src_tick  (src_tick),
  .bit_tick  (bit_tick),
  .half_tick (half_tick)
);

// File: tb/baud_mod_gen_test.sv
`timescale 1ns/1ps
module baud_mod_gen_test;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        soft_rst;
  logic        frame_start;
  logic [1:0]  src_sel;
  logic        ext_clk_in;
  logic        ext_inv;
  logic        aux_tick;
  logic [15:0] prescale;
  logic [7:0]  mod_pattern;
  logic        bit_tick;
  logic        half_tick;

  int n_run  = 0;
  int n_fail = 0;

  always #2.5 clk = ~clk;

  baud_mod_gen uut (
    .clk         (clk),
    .rst_n       (rst_n),
    .soft_rst    (soft_rst),
    .frame_start (frame_start),
    .src_sel     (src_sel),
    .ext_clk_in  (ext_clk_in),
    .ext_inv     (ext_inv),
    .aux_tick    (aux_tick),
    .prescale    (prescale),
    .mod_pattern (mod_pattern),
    .bit_tick    (bit_tick),
    .half_tick   (half_tick)
  );

  function automatic int base_of(input int n);
    return (n < 3) ? 3 : n;
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Restart (frame_start or soft_rst), then follow nper periods tick by tick
  task automatic run_check(input int sel, input int n, input logic [7:0] pat,
                           input int dens, input bit use_soft, input int nper,
                           input string tag);
    int ticks, idx, per, guard, lenx, halfx;
    bit prev_drive, d, eb, eh;
    @(negedge clk);
    src_sel = 2'(sel);
    repeat (7) begin
      aux_tick = ($urandom % 2) == 0;
      @(negedge clk);
    end
    prescale    = 16'(n);
    mod_pattern = pat;
    aux_tick    = 1'b0;
    if (use_soft) soft_rst = 1'b1; else frame_start = 1'b1;
    @(negedge clk);
    soft_rst = 1'b0;
    frame_start = 1'b0;
    chk(!bit_tick && !half_tick, use_soft ? "R7" : "R6", {bit_tick, half_tick}, 0);
    ticks = 0; idx = 0; per = 0; guard = 0; prev_drive = 1'b0;
    while (per < nper && guard < 20000) begin
      if (prev_drive) ticks++;
      lenx  = base_of(n) + int'(pat[idx]);
      halfx = base_of(n) / 2;
      eb = prev_drive && (ticks == lenx);
      eh = prev_drive && (ticks == halfx);
      if (eb || bit_tick)
        chk(bit_tick == eb, (per >= 8) ? "R3" : tag, ticks, lenx);
      if (eh || half_tick)
        chk(half_tick == eh, "R4", ticks, halfx);
      if (eb) begin
        ticks = 0;
        idx = (idx + 1) % 8;
        per++;
      end
      d = (sel >= 2) ? 1'b1 : (($urandom % 100) < dens);
      aux_tick   = d;
      prev_drive = d;
      @(negedge clk);
      guard++;
    end
    aux_tick = 1'b0;
    chk(per == nper, tag, per, nper);
  endtask

  // Count output pulses over a window of cycles
  task automatic count_pulses(input int cycles, output int nb, output int nh);
    nb = 0; nh = 0;
    repeat (cycles) begin
      @(negedge clk);
      nb += int'(bit_tick);
      nh += int'(half_tick);
    end
  endtask

  task automatic restart_pulse();
    @(negedge clk);
    frame_start = 1'b1;
    @(negedge clk);
    frame_start = 1'b0;
  endtask

  initial begin
    #(180000 * 5);
    n_fail++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    int nb, nh, t_prev, cyc, k;
    void'($urandom(32'd20240611));
    rst_n = 1'b0; soft_rst = 1'b0; frame_start = 1'b0; src_sel = 2'd1;
    ext_clk_in = 1'b0; ext_inv = 1'b0; aux_tick = 1'b0;
    prescale = 16'd3; mod_pattern = 8'h00;
    repeat (3) @(negedge clk);
    chk(!bit_tick && !half_tick, "R1", {bit_tick, half_tick}, 0);
    rst_n = 1'b1;
    count_pulses(10, nb, nh);
    chk(nb == 0 && nh == 0, "R1", nb + nh, 0);

    // Stated sequences, main clock
    run_check(2, 6, 8'h6F, 100, 1'b0, 16, "R2");
    run_check(3, 54, 8'hD5, 100, 1'b0, 16, "R2");
    // Clamp of small prescaler values
    run_check(2, 0, 8'h5A, 100, 1'b0, 10, "R5");
    run_check(2, 1, 8'hA5, 100, 1'b0, 10, "R5");
    run_check(1, 2, 8'h33, 60, 1'b0, 10, "R5");
    // Soft restart mid-period
    run_check(2, 10, 8'h02, 100, 1'b1, 10, "R7");
    run_check(1, 9, 8'hC3, 40, 1'b1, 10, "R7");
    // Sparse auxiliary strobes
    run_check(1, 5, 8'h81, 35, 1'b0, 16, "R8");
    // Random divisors and patterns
    for (int i = 0; i < 6; i++)
      run_check(1 + int'($urandom % 3), 3 + int'($urandom % 38),
                8'($urandom), 30 + int'($urandom % 70), 1'b0, 16, "R2");

    // No ticks from an idle auxiliary source
    @(negedge clk); src_sel = 2'd1; aux_tick = 1'b0; prescale = 16'd3;
    restart_pulse();
    count_pulses(40, nb, nh);
    chk(nb == 0 && nh == 0, "R8", nb + nh, 0);
    // No ticks from a static external pin
    @(negedge clk); src_sel = 2'd0; ext_clk_in = 1'b1; ext_inv = 1'b0;
    repeat (6) @(negedge clk);
    restart_pulse();
    count_pulses(40, nb, nh);
    chk(nb == 0 && nh == 0, "R8", nb + nh, 0);

    // Polarity: falling edge counted only when inverted (N=3, half at 1 tick)
    mod_pattern = 8'h00;
    ext_clk_in = 1'b1; ext_inv = 1'b1;
    repeat (6) @(negedge clk);
    restart_pulse();
    ext_clk_in = 1'b0;
    count_pulses(10, nb, nh);
    chk(nh == 1 && nb == 0, "R9", nh, 1);
    ext_clk_in = 1'b1; ext_inv = 1'b0;
    repeat (6) @(negedge clk);
    restart_pulse();
    ext_clk_in = 1'b0;
    count_pulses(10, nb, nh);
    chk(nh == 0 && nb == 0, "R9", nh, 0);
    ext_clk_in = 1'b1;
    count_pulses(10, nb, nh);
    chk(nh == 1 && nb == 0, "R9", nh, 1);

    // External clock of 4 cycles: bit period spacing is 4*(N+m)
    ext_clk_in = 1'b0; ext_inv = 1'b0; prescale = 16'd5; mod_pattern = 8'h09;
    repeat (6) @(negedge clk);
    restart_pulse();
    k = 0; cyc = 0; t_prev = 0;
    while (k < 10 && cyc < 2000) begin
      @(negedge clk);
      cyc++;
      if (cyc % 2 == 0) ext_clk_in = ~ext_clk_in;
      if (bit_tick) begin
        if (k >= 1)
          chk(cyc - t_prev == 4 * (5 + int'(mod_pattern[k % 8])), "R9",
              cyc - t_prev, 4 * (5 + int'(mod_pattern[k % 8])));
        t_prev = cyc;
        k++;
      end
    end
    chk(k == 10, "R9", k, 10);

    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule